// File: doc/BRIEF.md
# Clock-Setting Pulse Conditioner

This block drives the count pulses for the seconds, minutes and hours counters of a digital clock. A 0.1 s reference tick comes from outside the block. A divide-by-ten prescaler turns it into the 1 s timekeeping pulse. A function key moves the block through three setting states and normal running. In a setting state an adjust key creates count pulses for one selected counter: one step for each press, and one step per reference tick once the key has been held for a set number of ticks.

The block has three counter enables, and at any time exactly one of them is high. It also has one count-pulse output. In normal running that output carries the 1 s pulse. In a setting state it carries the adjust steps. A gate input can block the pulse output completely. The keys arrive already synchronized and debounced.

Top module: `set_pulse_cond`

## Requirements
- R1: While `rst_ni` is low, and at the first clock edge after reset, the block is in run mode: `sec_en_o`=1, `min_en_o`=0, `hr_en_o`=0 and `cnt_pulse_o`=0. The prescaler starts cleared, so the first run pulse follows the tenth tick after reset.
- R2: In run mode, `cnt_pulse_o` is high for exactly one cycle. It goes high one clock after every `DIV_RATIO`-th (10th) sampled `tick_i`, counting from reset. It is low at every other time.
- R3: Each rising edge of `func_key_i` advances the mode one step after the clock: run, then seconds-set, then minutes-set, then hours-set, then back to run. A key that stays high does not advance the mode again.
- R4: Exactly one enable is high. `sec_en_o` is high in run mode and in seconds-set, `min_en_o` in minutes-set, and `hr_en_o` in hours-set.
- R5: In a setting mode, a rising edge of `adj_key_i` gives one `cnt_pulse_o` cycle, one clock later.
- R6: In a setting mode, the adjust key may be held through `HOLD_TICKS` (5) sampled ticks. After that, every further tick while the key is still held gives one pulse, one clock later. Ticks before that point give no pulse.
- R7: In a setting mode, with the adjust key low, no pulse is delivered. Releasing the key clears the hold count, so the next press starts again with a single step.
- R8: In a setting mode, the 1 s run pulses are not delivered. The prescaler keeps counting ticks in every mode.
- R9: When `gate_en_i` is low during a cycle, no pulse results from that cycle. The enables and the mode are not affected.
- R10: In run mode, the adjust key has no effect on `cnt_pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 0.1 s reference tick, one cycle wide |
| func_key_i | input | 1 | Function key level, debounced |
| adj_key_i | input | 1 | Adjust key level, debounced |
| gate_en_i | input | 1 | Pulse output enable; low blocks all pulses |
| sec_en_o | output | 1 | Seconds counter enable |
| min_en_o | output | 1 | Minutes counter enable |
| hr_en_o | output | 1 | Hours counter enable |
| cnt_pulse_o | output | 1 | Selected count pulse, one cycle wide |

## Verification
The assertions assume that `tick_i`, `func_key_i` and `adj_key_i` are synchronous to `clk_i`, and that the keys are clean levels with no bounce. They assume that a tick is a single-cycle strobe. The stimulus changes inputs only on the falling clock edge. It raises each tick for exactly one cycle, spaced two or more cycles apart. It holds the keys steady across many cycles. It includes the two corner cases where a function-key edge and an adjust edge land in the same cycle, and where a mode change occurs while the adjust key is held.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN = 2'd0,
    MODE_SEC = 2'd1,
    MODE_MIN = 2'd2,
    MODE_HR  = 2'd3
  } spc_mode_e;

  localparam int unsigned NUM_TGT = 3;
endpackage

// File: rtl/spc_prescaler.sv
`timescale 1ns/1ps
module spc_prescaler #(
  parameter int unsigned DIV_RATIO = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic run_stb_o
);
  localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign run_stb_o = tick_i && (cnt_q == LAST);

  p_pre_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_pre_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/spc_hold_timer.sv
`timescale 1ns/1ps
module spc_hold_timer #(
  parameter int unsigned HOLD_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_i,
  input  logic arm_i,   // setting mode, no mode change this cycle
  output logic step_o
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] SAT = HW'(HOLD_TICKS);

  logic [HW-1:0] hold_q;
  logic          key_q;
  logic          key_rise, repeat_stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= 1'b0;
    else         key_q <= key_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hold_q <= '0;
    else if (!arm_i || !key_i)      hold_q <= '0;
    else if (tick_i && hold_q != SAT) hold_q <= hold_q + 1'b1;
  end

  assign key_rise   = key_i && !key_q;
  assign repeat_stb = tick_i && (hold_q == SAT);
  assign step_o     = arm_i && key_i && (key_rise || repeat_stb);

  p_hold_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= SAT);
  p_hold_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_i |=> (hold_q == '0));
  p_no_step_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_i |-> !step_o);
endmodule

// File: rtl/spc_mode_seq.sv
`timescale 1ns/1ps
module spc_mode_seq
  import spc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               func_key_i,
  output spc_mode_e          mode_o,
  output logic               func_rise_o,
  output logic [NUM_TGT-1:0] tgt_en_o
);
  spc_mode_e mode_q, mode_d;
  logic      func_q;

  assign func_rise_o = func_key_i && !func_q;

  always_comb begin
    mode_d = mode_q;
    if (func_rise_o) begin
      unique case (mode_q)
        MODE_RUN: mode_d = MODE_SEC;
        MODE_SEC: mode_d = MODE_MIN;
        MODE_MIN: mode_d = MODE_HR;
        default:  mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      func_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      func_q <= func_key_i;
    end
  end

  // target 0 = seconds (also run), 1 = minutes, 2 = hours
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_en
    if (g == 0) begin : g_sec
      assign tgt_en_o[g] = (mode_q == MODE_RUN) || (mode_q == MODE_SEC);
    end else begin : g_oth
      assign tgt_en_o[g] = (mode_q == spc_mode_e'(g + 1));
    end
  end

  assign mode_o = mode_q;

  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_key_i && !func_q) |=> (mode_q != $past(mode_q)));
  p_held_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(func_key_i && !func_q) |=> $stable(mode_q));
endmodule

// File: rtl/set_pulse_cond.sv
`timescale 1ns/1ps
module set_pulse_cond
  import spc_pkg::*;
#(
  parameter int unsigned DIV_RATIO  = 10,
  parameter int unsigned HOLD_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic func_key_i,
  input  logic adj_key_i,
  input  logic gate_en_i,
  output logic sec_en_o,
  output logic min_en_o,
  output logic hr_en_o,
  output logic cnt_pulse_o
);
  spc_mode_e          mode;
  logic               func_rise, run_stb, adj_step, arm, pulse_d, pulse_q;
  logic [NUM_TGT-1:0] tgt_en;

  spc_prescaler #(.DIV_RATIO(DIV_RATIO)) u_pre (
    .clk_i, .rst_ni, .tick_i, .run_stb_o(run_stb)
  );

  spc_mode_seq u_seq (
    .clk_i, .rst_ni, .func_key_i,
    .mode_o(mode), .func_rise_o(func_rise), .tgt_en_o(tgt_en)
  );

  assign arm = (mode != MODE_RUN) && !func_rise;

  spc_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i, .rst_ni, .tick_i, .key_i(adj_key_i), .arm_i(arm), .step_o(adj_step)
  );

  assign pulse_d = gate_en_i && ((mode == MODE_RUN) ? run_stb : adj_step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= pulse_d;
  end

  assign sec_en_o    = tgt_en[0];
  assign min_en_o    = tgt_en[1];
  assign hr_en_o     = tgt_en[2];
  assign cnt_pulse_o = pulse_q;

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sec_en_o, min_en_o, hr_en_o}) == 1);
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> !cnt_pulse_o);
  p_run_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_RUN && !tick_i) |=> !cnt_pulse_o);
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_RUN && !adj_key_i) |=> !cnt_pulse_o);
endmodule

// File: tb/set_pulse_cond_tb_top.sv
`timescale 1ns/1ps
module set_pulse_cond_tb_top;
  localparam int DIV = 10;
  localparam int HOLD = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, fkey = 1'b0, akey = 1'b0, gate = 1'b1;
  logic sec_en, min_en, hr_en, pulse;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  set_pulse_cond #(.DIV_RATIO(DIV), .HOLD_TICKS(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .func_key_i(fkey),
    .adj_key_i(akey), .gate_en_i(gate), .sec_en_o(sec_en), .min_en_o(min_en),
    .hr_en_o(hr_en), .cnt_pulse_o(pulse)
  );

  // behavioural reference: 0 run, 1 sec, 2 min, 3 hr
  int m_mode, m_pre, m_hold, m_pulse;
  bit m_fq, m_aq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pre = 0; m_hold = 0; m_pulse = 0; m_fq = 0; m_aq = 0;
    end else begin
      bit f_edge, a_edge, one_sec, armed, stepped;
      f_edge  = fkey && !m_fq;
      a_edge  = akey && !m_aq;
      one_sec = tick && (m_pre == DIV - 1);
      armed   = (m_mode != 0) && !f_edge;
      stepped = armed && akey && (a_edge || (tick && m_hold == HOLD));
      m_pulse = (gate && ((m_mode == 0) ? one_sec : stepped)) ? 1 : 0;
      if (!armed || !akey) m_hold = 0;
      else if (tick && m_hold < HOLD) m_hold++;
      if (tick) m_pre = (m_pre + 1) % DIV;
      if (f_edge) m_mode = (m_mode + 1) % 4;
      m_fq = fkey; m_aq = akey;
    end
  end

  task automatic compare(string tag);
    logic [2:0] exp_en;
    exp_en = {m_mode == 3, m_mode == 2, m_mode <= 1};
    n_chk++;
    if ({hr_en, min_en, sec_en} !== exp_en) begin
      n_bad++;
      $display("FAIL R4 enables (%s): got %b exp %b", tag, {hr_en, min_en, sec_en}, exp_en);
    end
    n_chk++;
    if (pulse !== m_pulse[0]) begin
      n_bad++;
      $display("FAIL %s pulse: got %b exp %b", tag, pulse, m_pulse[0]);
    end
  endtask

  // n cycles, tick raised on every k-th cycle (k=0: none)
  task automatic run(int n, int k, string tag);
    for (int i = 0; i < n; i++) begin
      tick = (k != 0) && (i % k == k - 1);
      @(posedge clk); @(negedge clk);
      compare(tag);
    end
    tick = 1'b0;
  endtask

  task automatic press_func(string tag);
    fkey = 1'b1; run(4, 0, tag);
    fkey = 1'b0; run(2, 0, tag);
  endtask

  task automatic short_adj(string tag);
    akey = 1'b1; run(3, 0, tag);
    akey = 1'b0; run(2, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(3, 0, "R1 reset");
    rst_n = 1'b1;
    run(1, 0, "R1 first cycle");
    // run mode timekeeping
    run(70, 3, "R2 run pulses");
    run(45, 4, "R2 run pulses slow");
    // adjust key ignored in run mode
    akey = 1'b1; run(35, 2, "R10 adj in run");
    akey = 1'b0; run(10, 2, "R10 adj released");
    // seconds-set
    press_func("R3 to sec");
    run(30, 2, "R8 no run pulse in set");
    short_adj("R5 single step");
    short_adj("R5 second step");
    akey = 1'b1; run(40, 3, "R6 auto-repeat");
    akey = 1'b0; run(25, 2, "R7 released");
    akey = 1'b1; run(9, 3, "R7 restart below hold");
    akey = 1'b0; run(4, 0, "R7 released again");
    // minutes-set, mode change while adj held
    akey = 1'b1; fkey = 1'b1; run(3, 0, "R3 to min with adj");
    fkey = 1'b0; run(30, 2, "R6 held across change");
    akey = 1'b0; run(3, 0, "R7 release");
    short_adj("R5 min step");
    // hours-set with gate low
    press_func("R3 to hr");
    gate = 1'b0;
    short_adj("R9 gated step");
    akey = 1'b1; run(30, 2, "R9 gated repeat");
    akey = 1'b0;
    gate = 1'b1;
    short_adj("R5 hr step");
    // wrap to run, simultaneous edges
    akey = 1'b1; fkey = 1'b1; run(3, 0, "R3 wrap to run");
    fkey = 1'b0; akey = 1'b0;
    run(40, 2, "R2 run after wrap");
    gate = 1'b0; run(40, 2, "R9 gated run");
    gate = 1'b1; run(30, 2, "R2 ungated run");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule